// File: doc/BRIEF.md
# UART Receive Status and Interrupt Logic

This block is the receive-side status stage of one asynchronous serial channel. A deserializer hands it each assembled character together with the parity bit and the stop bit it sampled. The block tags the character with parity and framing errors and queues it in a four-entry receive FIFO. Each entry keeps its own tags. When a character arrives while the FIFO is full, the character is dropped and an overrun is recorded.

The status outputs are data-ready, overrun, parity error, framing error and carrier detect. The block also drives a receive interrupt request. Error flags describe the character at the head of the FIFO. They appear only when a faulty character becomes the oldest entry. A carrier-detect pin can hold the error flags clear, and it raises an interrupt when it goes high. Bit sampling, baud generation and bus decoding sit outside this block.

Top module: `uart_rx_status`

## Requirements
- R1: Characters leave in arrival order. `rx_dout` shows the oldest entry. A `data_rd` pulse removes that entry when the FIFO is not empty. `st_ready` is 1 exactly when the FIFO holds at least one entry.
- R2: The FIFO holds 4 entries. A character that arrives when 4 entries are held and no pop happens in the same cycle is discarded, and the stored entries are kept. In that case `st_ovrn` becomes 1 on the next cycle and stays set until it is cleared.
- R3: When `par_en` is 1, a character gets a parity tag if the number of ones in its 8 data bits plus `rx_par` is odd while `par_odd` is 0, or even while `par_odd` is 1. When `par_en` is 0, no character gets a parity tag.
- R4: A character whose `rx_stop` input is 0 gets a framing tag.
- R5: `st_perr` and `st_ferr` are set in the cycle after a tagged character becomes the FIFO head, whether it arrives into an empty FIFO or is exposed by a pop. A tagged character held behind an older entry does not set them.
- R6: An `err_clr` pulse clears `st_perr`, `st_ferr` and `st_ovrn` on the next edge. A clear takes priority over a set in the same cycle.
- R7: While `io_stop` is 1, the FIFO is emptied, incoming characters and reads are ignored, and the overrun, parity and framing flags are cleared.
- R8: While `dcd_auto` is 1 and `dcd_n` is 1, `st_perr` and `st_ferr` are held at 0.
- R9: `st_dcd` is 1 in the cycle after `dcd_n` is sampled high. After the pin goes low, `st_dcd` stays 1 until the first `stat_rd` pulse and then becomes 0. `st_dcd` is 0 after reset.
- R10: `rx_irq` is `rx_ie` AND (data-ready with `dma_rx_sel` low, OR overrun, OR parity error, OR framing error, OR `st_dcd`). The DMA routing input suppresses only the data-ready term.
- R11: After reset the FIFO is empty and all status bits and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer delivers a character this cycle |
| rx_data | input | 8 | Received data bits |
| rx_par | input | 1 | Received parity bit |
| rx_stop | input | 1 | Sampled stop bit (0 = framing fault) |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity expected, 0 = even |
| data_rd | input | 1 | Data register read; pops the head entry |
| stat_rd | input | 1 | Status register read strobe |
| err_clr | input | 1 | Error flag reset pulse |
| io_stop | input | 1 | I/O stop mode |
| dcd_n | input | 1 | Carrier-detect pin, high = negated |
| dcd_auto | input | 1 | Carrier-detect auto-enable |
| rx_ie | input | 1 | Receive interrupt enable |
| dma_rx_sel | input | 1 | A DMA channel takes receive data from this channel |
| rx_dout | output | 8 | Data of the oldest FIFO entry |
| st_ready | output | 1 | Receive data ready (FIFO not empty) |
| st_ovrn | output | 1 | Overrun flag |
| st_perr | output | 1 | Parity error flag |
| st_ferr | output | 1 | Framing error flag |
| st_dcd | output | 1 | Carrier-detect status |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Directed sequences fill the FIFO past capacity to separate a correctly dropped fifth character from one that overwrites or shifts a stored entry. They push a faulty character behind a clean one to show whether flags follow the head or the arrival. They test parity with both senses and with checking disabled, so that an inverted or ignored sense is exposed. Random traffic mixes arrivals, pops on a full FIFO, clears, stop mode, carrier-pin toggles and DMA routing, which separates the priority between clear and set and the pop-and-push corner cases from the plain paths. Carrier-detect sequences and status reads show whether the status bit clears only on a read after the pin falls.

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_par,
  input  logic          rx_stop,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          data_rd,
  input  logic          stat_rd,
  input  logic          err_clr,
  input  logic          io_stop,
  input  logic          dcd_n,
  input  logic          dcd_auto,
  input  logic          rx_ie,
  input  logic          dma_rx_sel,
  output logic [DW-1:0] rx_dout,
  output logic          st_ready,
  output logic          st_ovrn,
  output logic          st_perr,
  output logic          st_ferr,
  output logic          st_dcd,
  output logic          rx_irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam int EW = DW + 2;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  logic          full, pop, push, head_new, clr_err, clr_ovr;
  logic          in_pe, in_fe;
  logic [EW-1:0] in_entry, next_head;

  assign full     = (count == CW'(DEPTH));
  assign pop      = data_rd && (count != '0) && !io_stop;
  assign push     = rx_valid && !io_stop && (!full || pop);
  assign in_pe    = par_en && ((^{rx_data, rx_par}) != par_odd);
  assign in_fe    = !rx_stop;
  assign in_entry = {in_pe, in_fe, rx_data};

  assign head_new  = (push && count == '0) || (pop && (count > CW'(1) || push));
  assign next_head = (pop && count > CW'(1)) ? mem[AW'(rd_ptr + 1'b1)] : in_entry;

  assign clr_ovr = err_clr || io_stop;
  assign clr_err = clr_ovr || (dcd_auto && dcd_n);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || io_stop) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= AW'(wr_ptr + 1'b1);
      if (pop)  rd_ptr <= AW'(rd_ptr + 1'b1);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_ovrn <= 1'b0;
      st_perr <= 1'b0;
      st_ferr <= 1'b0;
      st_dcd  <= 1'b0;
    end else begin
      if (clr_ovr)                        st_ovrn <= 1'b0;
      else if (rx_valid && !push)         st_ovrn <= 1'b1;
      if (clr_err)                        st_perr <= 1'b0;
      else if (head_new && next_head[DW+1]) st_perr <= 1'b1;
      if (clr_err)                        st_ferr <= 1'b0;
      else if (head_new && next_head[DW])   st_ferr <= 1'b1;
      if (dcd_n)                          st_dcd  <= 1'b1;
      else if (stat_rd)                   st_dcd  <= 1'b0;
    end
  end

  assign rx_dout  = mem[rd_ptr][DW-1:0];
  assign st_ready = (count != '0);
  assign rx_irq   = rx_ie && ((st_ready && !dma_rx_sel) || st_ovrn || st_perr || st_ferr || st_dcd);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_overrun_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full && !data_rd && !io_stop && !err_clr) |=> st_ovrn);

  assert_pop_drops_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CW'(1)));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (!st_perr && !st_ferr && !st_ovrn));

  assert_stop_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_stop |=> (!st_ready && !st_ovrn));

  assert_dcd_hold_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_auto && dcd_n) |=> (!st_perr && !st_ferr));

  assert_dcd_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dcd_n |=> st_dcd);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !rx_irq);
endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_par = 0, rx_stop = 1, par_en = 0, par_odd = 0;
  logic data_rd = 0, stat_rd = 0, err_clr = 0, io_stop = 0;
  logic dcd_n = 0, dcd_auto = 0, rx_ie = 0, dma_rx_sel = 0;
  logic [7:0] rx_data = 0;
  logic [7:0] rx_dout;
  logic st_ready, st_ovrn, st_perr, st_ferr, st_dcd, rx_irq;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [7:0] q_d [4];
  logic       q_p [4];
  logic       q_f [4];
  int         m_cnt;
  logic       m_ovr, m_pe, m_fe, m_dcd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par(rx_par), .rx_stop(rx_stop), .par_en(par_en), .par_odd(par_odd),
    .data_rd(data_rd), .stat_rd(stat_rd), .err_clr(err_clr), .io_stop(io_stop),
    .dcd_n(dcd_n), .dcd_auto(dcd_auto), .rx_ie(rx_ie), .dma_rx_sel(dma_rx_sel),
    .rx_dout(rx_dout), .st_ready(st_ready), .st_ovrn(st_ovrn), .st_perr(st_perr),
    .st_ferr(st_ferr), .st_dcd(st_dcd), .rx_irq(rx_irq));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_tag(logic [7:0] d, logic p, logic en, logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    ones += p;
    return en && ((ones % 2 == 1) != odd);
  endfunction

  function automatic logic exp_irq();
    return rx_ie && (((m_cnt > 0) && !dma_rx_sel) || m_ovr || m_pe || m_fe || m_dcd);
  endfunction

  task automatic model_step();
    logic pop, acc, arrive, hp, hf, tp, tf, clr;
    tp  = par_tag(rx_data, rx_par, par_en, par_odd);
    tf  = !rx_stop;
    clr = err_clr || io_stop || (dcd_auto && dcd_n);
    pop = data_rd && m_cnt > 0 && !io_stop;
    acc = rx_valid && !io_stop && (m_cnt < 4 || pop);
    arrive = (acc && m_cnt == 0) || (pop && (m_cnt >= 2 || acc));
    if (pop && m_cnt >= 2) begin hp = q_p[1]; hf = q_f[1]; end
    else begin hp = tp; hf = tf; end
    if (err_clr || io_stop) m_ovr = 0;
    else if (rx_valid && !acc) m_ovr = 1;
    if (clr) begin m_pe = 0; m_fe = 0; end
    else if (arrive) begin
      if (hp) m_pe = 1;
      if (hf) m_fe = 1;
    end
    if (dcd_n) m_dcd = 1;
    else if (stat_rd) m_dcd = 0;
    if (pop) begin
      for (int i = 0; i < 3; i++) begin q_d[i] = q_d[i+1]; q_p[i] = q_p[i+1]; q_f[i] = q_f[i+1]; end
      m_cnt--;
    end
    if (acc) begin q_d[m_cnt] = rx_data; q_p[m_cnt] = tp; q_f[m_cnt] = tf; m_cnt++; end
    if (io_stop) m_cnt = 0;
  endtask

  task automatic compare_all();
    chk("R1", "st_ready", st_ready, m_cnt > 0);
    if (m_cnt > 0) chk("R1", "rx_dout", rx_dout, q_d[0]);
    chk("R2", "st_ovrn", st_ovrn, m_ovr);
    chk("R5", "st_perr", st_perr, m_pe);
    chk("R5", "st_ferr", st_ferr, m_fe);
    chk("R9", "st_dcd", st_dcd, m_dcd);
    chk("R10", "rx_irq", rx_irq, exp_irq());
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
    @(negedge clk);
    rx_valid = 0; data_rd = 0; stat_rd = 0; err_clr = 0;
  endtask

  task automatic send(logic [7:0] d, logic p, logic s);
    rx_valid = 1; rx_data = d; rx_par = p; rx_stop = s;
    step();
  endtask

  task automatic pop1();
    data_rd = 1;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24680));
    m_cnt = 0; m_ovr = 0; m_pe = 0; m_fe = 0; m_dcd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R11", "ready after reset", st_ready, 0);
    chk("R11", "flags after reset", {st_ovrn, st_perr, st_ferr, st_dcd}, 4'b0000);
    chk("R11", "irq after reset", rx_irq, 0);
    @(negedge clk);

    // R1/R2: fill past capacity, then drain in order
    rx_ie = 1;
    send(8'hA1, 0, 1); send(8'hA2, 0, 1); send(8'hA3, 0, 1); send(8'hA4, 0, 1);
    send(8'hEE, 0, 1);
    chk("R2", "overrun after fifth", st_ovrn, 1);
    chk("R2", "head kept", rx_dout, 8'hA1);
    pop1(); chk("R1", "order 2", rx_dout, 8'hA2);
    pop1(); chk("R1", "order 3", rx_dout, 8'hA3);
    pop1(); chk("R1", "order 4", rx_dout, 8'hA4);
    pop1(); chk("R1", "empty after drain", st_ready, 0);
    err_clr = 1; step();
    chk("R6", "ovrn cleared", st_ovrn, 0);

    // R3: parity senses and disable
    par_en = 1; par_odd = 0;
    send(8'h03, 1, 1);
    chk("R3", "even sense error", st_perr, 1);
    pop1(); err_clr = 1; step();
    chk("R6", "perr cleared", st_perr, 0);
    par_odd = 1;
    send(8'h03, 1, 1);
    chk("R3", "odd sense ok", st_perr, 0);
    pop1();
    par_en = 0; par_odd = 0;
    send(8'h03, 1, 1);
    chk("R3", "disabled no error", st_perr, 0);
    pop1();

    // R4/R5: faulty char behind clean head
    send(8'h11, 0, 1);
    send(8'h22, 0, 0);
    chk("R5", "hidden behind head", st_ferr, 0);
    pop1();
    chk("R4", "framing at head", st_ferr, 1);
    pop1();

    // R8/R9: carrier detect
    dcd_auto = 1; dcd_n = 1; step();
    chk("R8", "auto clears ferr", st_ferr, 0);
    chk("R9", "dcd high", st_dcd, 1);
    chk("R10", "dcd irq", rx_irq, 1);
    dcd_n = 0; step();
    chk("R9", "dcd held after fall", st_dcd, 1);
    stat_rd = 1; step();
    chk("R9", "dcd cleared by read", st_dcd, 0);
    dcd_auto = 0;

    // R10: DMA suppresses data-ready interrupt
    dma_rx_sel = 1;
    send(8'h55, 0, 1);
    chk("R10", "dma suppresses", rx_irq, 0);
    dma_rx_sel = 0; step();
    chk("R10", "ready irq", rx_irq, 1);

    // R7: stop mode flush
    send(8'h66, 0, 0);
    io_stop = 1; rx_valid = 1; rx_data = 8'h77; step();
    chk("R7", "flushed", st_ready, 0);
    chk("R7", "flags cleared", {st_ovrn, st_ferr}, 2'b00);
    io_stop = 0;

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 50 == 0) begin
        par_en = $urandom_range(1); par_odd = $urandom_range(1);
        dcd_auto = $urandom_range(1); rx_ie = $urandom_range(1);
        dma_rx_sel = $urandom_range(1);
      end
      rx_valid = ($urandom_range(99) < 45);
      rx_data  = 8'($urandom);
      rx_par   = $urandom_range(1);
      rx_stop  = ($urandom_range(99) < 85);
      data_rd  = ($urandom_range(99) < 30);
      stat_rd  = ($urandom_range(99) < 10);
      err_clr  = ($urandom_range(99) < 4);
      io_stop  = ($urandom_range(99) < 2);
      if ($urandom_range(99) < 5) dcd_n = ~dcd_n;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule